// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs continuously from a single clock. It advances through a prescaler built on a 4-bit divider. Software picks the divide ratio through a 2-bit select field. A newly written ratio does not take effect at once. It waits until the 4-bit divider rolls over from 15 to 0, so the count never sees a partial prescale period.

The count is read over an 8-bit register port, most significant byte first. Reading the upper byte also stores the lower byte of the same count value. A later read of the lower byte returns that stored copy and not the live count. The two bytes therefore always describe one count value, even if the counter moves on between the two reads.

Every port access takes one clock. The read strobe is sampled on a rising edge, and the addressed byte appears on the read data port after that same edge.

Top module: `tmr_coherent_timer`

## Requirements
- R1: Reset is synchronous and active high. It clears the count, the 4-bit divider, the stored low byte and the read data to zero, and sets both the written and the applied select to 0 (divide by 1).
- R2: Select value 0 divides by 1, 1 by 4, 2 by 8 and 3 by 16. Under a ratio of N, the count rises by exactly one on the edge where the low log2(N) bits of the divider are all ones, and it holds on every other edge.
- R3: A written select value becomes the applied ratio only on the edge where the divider goes from 15 to 0. Until then the previous ratio keeps clocking the count.
- R4: A read at address 0 returns bits 15:8 of the count on the edge that samples it. On the same edge it stores bits 7:0 of that same count value.
- R5: A read at address 1 returns the stored low byte, not the live low byte, even when the count has advanced since the address-0 read.
- R6: A read at address 1 with no address-0 read before it returns whatever the last address-0 read stored, or zero if no address-0 read has occurred since reset.
- R7: After 16'hFFFF the count wraps to 16'h0000 and keeps counting.
- R8: A write to address 2 loads the select from write data bits 1:0. A read at address 2 returns the written select in bits 1:0 with zeros above. A read at address 3 returns zero. Writes to addresses 0, 1 and 3 change neither the count nor the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for counter, divider and port |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 count high, 1 stored count low, 2 select, 3 unused |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data; bits 1:0 carry the select |
| bus_rdata | output | 8 | Registered read data, updated on the edge that samples bus_rd |

## Verification
The bench builds the block with its default widths: a 16-bit count, an 8-bit port, a 4-bit divider and a 2-bit select. At divide by 1, these widths put the 16'hFFFF to 16'h0000 rollover within about 65,000 clocks. The byte carry from 16'h12FF to 16'h1300 can then fall exactly between the two halves of a read. The 4-bit divider makes every ratio change wait at most 16 clocks. That lets the bench write a new select in the middle of a divider period and watch the old rate continue before the new one starts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register map of the byte-wide port
  typedef enum logic [1:0] {
    A_CNT_HI = 2'd0,
    A_CNT_LO = 2'd1,
    A_CTRL   = 2'd2,
    A_SPARE  = 2'd3
  } tmr_addr_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_req,
  output logic [SEL_W-1:0] sel_act,
  output logic             tick
);

  localparam int NSEL = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] act_q;
  logic [NSEL-1:0]  tap_hit;
  logic             wrap;

  // One tap comparator per select code: code 0 fires every cycle,
  // code k>0 fires when the low k+1 divider bits are all ones.
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int LOGR = (g == 0) ? 0 : ((g + 1 > PRE_W) ? PRE_W : g + 1);
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << LOGR) - 1);
    assign tap_hit[g] = ((pre_q & MASK) == MASK);
  end

  assign wrap    = &pre_q;
  assign tick    = tap_hit[act_q];
  assign sel_act = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (wrap) act_q <= sel_req;
    end
  end

  // R3: the applied ratio only moves on the edge leaving divider state all-ones
  p_act_at_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(act_q)) |-> ($past(pre_q) == '1));

  // R2: the divider steps by one every clock outside reset
  p_pre_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pre_q == $past(pre_q) + 1'b1));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R7: all-ones plus one tick gives zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick) && ($past(cnt_q) == '1)) |-> (cnt_q == '0));

  // R2: without a prescaler tick the count holds
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> $stable(cnt_q));

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [SEL_W-1:0]  sel_req,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] lo_buf;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wbits;
  tmr_addr_e         a;

  assign a            = tmr_addr_e'(addr);
  assign unused_wbits = ^wdata[DATA_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_buf  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && a == A_CTRL) sel_q <= wdata[SEL_W-1:0];
      if (rd_en) begin
        case (a)
          A_CNT_HI: begin
            rdata_q <= cnt[CNT_W-1 -: DATA_W];
            lo_buf  <= cnt[DATA_W-1:0];
          end
          A_CNT_LO: rdata_q <= lo_buf;
          A_CTRL:   rdata_q <= DATA_W'(sel_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign sel_req = sel_q;
  assign rdata   = rdata_q;

  // R4: an upper-byte read freezes the lower byte of the same count value
  p_hi_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a == A_CNT_HI) |=> (lo_buf == $past(cnt[DATA_W-1:0])));

  // R6: the stored byte is untouched by anything but an upper-byte read
  p_buf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && a == A_CNT_HI) |=> $stable(lo_buf));

  // R5: a lower-byte read returns the stored copy
  p_lo_from_buf_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a == A_CNT_LO) |=> (rdata == $past(lo_buf)));

  // R8: select readback has zeros above the field
  p_ctrl_pad_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a == A_CTRL) |=> (rdata[DATA_W-1:SEL_W] == '0));

endmodule

// File: rtl/tmr_coherent_timer.sv
module tmr_coherent_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int PRE_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic             tick;
  logic [SEL_W-1:0] sel_req;
  logic [SEL_W-1:0] sel_act;
  logic [CNT_W-1:0] cnt;

  tmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .sel_req (sel_req),
    .sel_act (sel_act),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .cnt  (cnt)
  );

  tmr_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .rd_en   (bus_rd),
    .wr_en   (bus_wr),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .sel_req (sel_req),
    .rdata   (bus_rdata)
  );

  // R1: the first clock after reset sees a cleared count, ratio and read data
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && sel_act == '0 && sel_req == '0 && bus_rdata == '0));

endmodule

// File: tb/sim_tmr_coherent_timer.sv
`timescale 1ns/1ps
module sim_tmr_coherent_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  always #4 clk = ~clk;

  tmr_coherent_timer u0 (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_rd (bus_rd),
    .bus_wr (bus_wr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model built from the requirements
  logic [15:0] m_cnt;
  int          m_pre;
  logic [1:0]  m_act, m_req;
  logic [7:0]  m_buf;

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_cnt <= 16'd0; m_pre <= 0; m_act <= 2'd0; m_req <= 2'd0;
    end else begin
      m_pre <= (m_pre + 1) % 16;
      if (m_pre == 15) m_act <= m_req;
      if (bus_wr && bus_addr == 2'd2) m_req <= bus_wdata[1:0];
      if ((m_pre % ratio_of(m_act)) == ratio_of(m_act) - 1) m_cnt <= m_cnt + 16'd1;
    end
  end

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  // Monitor: compares each expected item in the cycle it falls due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s got %02h expected %02h (cycle %0d)", it.req, bus_rdata, it.exp, cyc);
      end
    end
  end

  // Driver: one-cycle read strobe, expectation pushed from the model
  task automatic bus_read(input logic [1:0] a, input string req);
    item_t it;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    case (a)
      2'd0: begin it.exp = m_cnt[15:8]; m_buf = m_cnt[7:0]; end
      2'd1: it.exp = m_buf;
      2'd2: it.exp = {6'd0, m_req};
      default: it.exp = 8'd0;
    endcase
    it.due = cyc + 1;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_count(input logic [15:0] v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    m_buf = 8'd0;
    repeat (4) @(negedge clk);
    // R1: read data cleared while reset is held
    checks++;
    if (bus_rdata !== 8'd0) begin
      errors++;
      $display("FAIL R1 reset rdata got %02h expected 00", bus_rdata);
    end
    rst = 1'b0;

    // R1 / R6: stored byte and select are zero before any upper read
    bus_read(2'd1, "R6 low before any high read");
    bus_read(2'd2, "R1 select after reset");
    bus_read(2'd3, "R8 spare address reads zero");
    idle(3);

    // R4 / R5: byte carry between the two halves
    wait_count(16'h12FD);
    bus_read(2'd0, "R4 high at byte carry");
    bus_read(2'd1, "R5 low from stored copy at carry");
    idle(10);
    bus_read(2'd1, "R6 repeated low without new high");
    idle(2);

    // R8: writes to count addresses are ignored
    bus_write(2'd0, 8'hAA);
    bus_write(2'd1, 8'h55);
    bus_write(2'd3, 8'hFF);
    idle(2);
    bus_read(2'd2, "R8 select unchanged by other writes");
    bus_read(2'd0, "R8 count high after ignored writes");
    bus_read(2'd1, "R8 count low after ignored writes");
    idle(2);

    // R7: rollover
    wait_count(16'hFFFD);
    bus_read(2'd0, "R7 high at all-ones");
    bus_read(2'd1, "R7 low at all-ones");
    bus_read(2'd0, "R7 high after wrap");
    bus_read(2'd1, "R7 low after wrap");
    idle(2);

    // R3: switch to divide by 16 mid-period; old rate runs until divider wraps
    while (m_pre != 3) @(negedge clk);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, "R8 select readback");
    bus_read(2'd0, "R3 high before applied wrap");
    bus_read(2'd1, "R3 low before applied wrap");
    idle(4);
    bus_read(2'd0, "R3 high still at old rate");
    bus_read(2'd1, "R3 low still at old rate");
    idle(20);
    bus_read(2'd0, "R3 high after new rate applied");
    bus_read(2'd1, "R3 low after new rate applied");
    idle(2);

    // R2: every ratio, sampled at two spacings
    for (int s = 0; s < 4; s++) begin
      bus_write(2'd2, 8'(s));
      idle(37);
      bus_read(2'd0, "R2 ratio high A");
      bus_read(2'd1, "R2 ratio low A");
      idle(23);
      bus_read(2'd0, "R2 ratio high B");
      bus_read(2'd1, "R2 ratio low B");
      idle(5);
    end

    idle(4);
    finish_run();
  end

endmodule